// File: doc/BRIEF.md
# Cached Multi-Page Write Sequencer

This block sits between a byte-level write front end and a nonvolatile array that is programmed one page at a time. A transaction opens with a start pulse carrying a byte address. The data bytes that follow go into a 64-byte staging cache, which is organised as 8 cache pages of 8 bytes. The first byte lands at the in-page offset of the start address, and loading wraps around inside the cache. A per-byte valid mask records which cache positions were loaded.

When the stop pulse arrives, the block flushes the cache into the array. Cache page k is programmed into array page (start page + k). The page counter carries from the page-in-row field into the row field, so a flush runs on across row boundaries. For each cache page that holds loaded bytes, the block holds a page-write request until the array acknowledges it. It then waits a fixed program time before it moves on.

The busy flag covers the whole flush. While busy is high, all new transaction inputs are ignored.

Top module: `cached_page_writer`

## Requirements
- R1: After reset, `busy` and `pg_req` are low, and no page write is issued until a transaction has been loaded and stopped.
- R2: The first data byte after `wr_start` is stored at cache position `wr_addr[2:0]` of cache page 0, and each following byte goes to the next position. On `pg_data`, byte b of a page occupies bits [8b+7:8b].
- R3: Loading wraps modulo 64. The byte after cache position 63 goes to position 0, and later bytes overwrite earlier ones at the same position.
- R4: No page write is requested before `wr_stop`. A stop with at least one loaded byte raises `busy` on the clock edge that samples the stop.
- R5: Cache page k is written to array page `wr_addr[ADDR_W-1:3] + k`, counted modulo 2^(ADDR_W-3). A carry out of the 3-bit page-in-row field advances the row field.
- R6: Exactly one page write is issued for each cache page that holds at least one loaded byte, in increasing k. Its `pg_mask` bit b is set exactly when cache byte b of that page was loaded. Empty cache pages are skipped.
- R7: `pg_req`, `pg_addr`, `pg_data` and `pg_mask` stay unchanged until `pg_done` is sampled high. `pg_req` then drops, and the next request rises no earlier than WR_CYCLES+1 edges after the edge that sampled `pg_done`.
- R8: `busy` falls WR_CYCLES edges after the last acknowledged page write, plus one edge for each empty cache page that follows it.
- R9: While `busy` is high, `wr_start`, `byte_valid` and `wr_stop` have no effect. Bytes and stops given with no open transaction are ignored.
- R10: A stop with no loaded bytes ends the transaction without any page write, and `busy` stays low.
- R11: A byte presented in the same cycle as `wr_stop` is stored and included in the flush.
- R12: A `wr_start` while bytes are being loaded begins a fresh transaction. Bytes loaded before it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Opens a transaction and captures `wr_addr` |
| wr_addr | input | ADDR_W | Start byte address |
| byte_valid | input | 1 | Data byte present on `byte_data` |
| byte_data | input | 8 | Data byte |
| wr_stop | input | 1 | Closes the transaction and starts the flush |
| pg_req | output | 1 | Page-write request to the array |
| pg_addr | output | ADDR_W-3 | Target array page number (row and page-in-row) |
| pg_data | output | 8*PAGE_BYTES | Page contents, byte b at bits [8b+7:8b] |
| pg_mask | output | PAGE_BYTES | Bytes of the page to program |
| pg_done | input | 1 | Array acknowledgement of the page write |
| busy | output | 1 | Flush in progress |

## Verification
`busy` is due on the edge that samples the stop. The bench checks it at the next falling edge. Each page request is held until the bench's array model raises `pg_done`. The model does this after a fixed latency and records the edge number of the acknowledgement.

The bench derives the spacing to the next request (at least WR_CYCLES+1 edges) and the fall of `busy` from that recorded edge. The fall is due WR_CYCLES edges later plus one edge per trailing empty cache page, and the bench compares edge counts exactly. All inputs are driven, and all outputs sampled, on falling edges.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_PICK,
    SQ_REQ,
    SQ_HOLD
  } seq_state_t;

endpackage

// File: rtl/cpw_cache_store.sv
module cpw_cache_store #(
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    we_i,
  input  logic [$clog2(PAGE_BYTES*CACHE_PAGES)-1:0] widx_i,
  input  logic [7:0]              wdata_i,
  input  logic [$clog2(CACHE_PAGES)-1:0] rpage_i,
  output logic [8*PAGE_BYTES-1:0] rdata_o,
  output logic [PAGE_BYTES-1:0]   rmask_o,
  output logic                    any_o
);

  localparam int CACHE_BYTES = PAGE_BYTES * CACHE_PAGES;
  localparam int OFS_W       = $clog2(PAGE_BYTES);

  logic [7:0]             mem [CACHE_BYTES];
  logic [CACHE_BYTES-1:0] vld_q;
  logic [CACHE_BYTES-1:0] vld_d;

  // valid mask: cleared on a new transaction, set per loaded byte
  always_comb begin
    vld_d = vld_q;
    if (clr_i) begin
      vld_d = '0;
    end else if (we_i) begin
      vld_d[widx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // data storage needs no reset: the mask qualifies every byte
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[widx_i] <= wdata_i;
    end
  end

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_rd
    localparam logic [OFS_W-1:0] BOFS = OFS_W'(b);
    assign rdata_o[8*b +: 8] = mem[{rpage_i, BOFS}];
    assign rmask_o[b]        = vld_q[{rpage_i, BOFS}];
  end

  assign any_o = |vld_q;

endmodule

// File: rtl/cpw_cursor.sv
module cpw_cursor #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adv_ptr_i,
  input  logic                    step_i,
  output logic [$clog2(PAGE_BYTES*CACHE_PAGES)-1:0] wptr_o,
  output logic [$clog2(CACHE_PAGES)-1:0] cpg_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] tgt_o,
  output logic                    last_o
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int CPG_W  = $clog2(CACHE_PAGES);
  localparam int CIDX_W = OFS_W + CPG_W;
  localparam int PNUM_W = ADDR_W - OFS_W;

  logic [CIDX_W-1:0] wptr_q, wptr_d;
  logic [CPG_W-1:0]  cpg_q,  cpg_d;
  logic [PNUM_W-1:0] tgt_q,  tgt_d;

  always_comb begin
    wptr_d = wptr_q;
    cpg_d  = cpg_q;
    tgt_d  = tgt_q;
    if (load_i) begin
      // first byte at the in-page offset of cache page 0
      wptr_d = {CPG_W'(0), addr_i[OFS_W-1:0]};
      cpg_d  = '0;
      tgt_d  = addr_i[ADDR_W-1:OFS_W];
    end else begin
      if (adv_ptr_i) begin
        wptr_d = wptr_q + 1'b1;   // power-of-two cache: natural wrap
      end
      if (step_i) begin
        cpg_d = cpg_q + 1'b1;
        tgt_d = tgt_q + 1'b1;     // carry runs from page field into row field
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cpg_q  <= '0;
      tgt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cpg_q  <= cpg_d;
      tgt_q  <= tgt_d;
    end
  end

  assign wptr_o = wptr_q;
  assign cpg_o  = cpg_q;
  assign tgt_o  = tgt_q;
  assign last_o = (cpg_q == CPG_W'(CACHE_PAGES - 1));

endmodule

// File: rtl/cpw_ctrl.sv
module cpw_ctrl #(
  parameter int WR_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_start_i,
  input  logic byte_valid_i,
  input  logic wr_stop_i,
  input  logic any_i,
  input  logic page_has_i,
  input  logic last_i,
  input  logic pg_done_i,
  output logic clr_o,
  output logic load_o,
  output logic we_o,
  output logic step_o,
  output logic pg_req_o,
  output logic busy_o
);

  import cpw_pkg::*;

  localparam int TMR_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(WR_CYCLES - 1);

  seq_state_t       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    clr_o  = 1'b0;
    load_o = 1'b0;
    we_o   = 1'b0;
    step_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (wr_start_i) begin
          clr_o  = 1'b1;
          load_o = 1'b1;
          st_d   = SQ_LOAD;
        end
      end
      SQ_LOAD: begin
        if (wr_start_i) begin
          clr_o  = 1'b1;
          load_o = 1'b1;
        end else begin
          we_o = byte_valid_i;
          if (wr_stop_i) begin
            st_d = (any_i || byte_valid_i) ? SQ_PICK : SQ_IDLE;
          end
        end
      end
      SQ_PICK: begin
        if (page_has_i) begin
          st_d = SQ_REQ;
        end else if (last_i) begin
          st_d = SQ_IDLE;
        end else begin
          step_o = 1'b1;
        end
      end
      SQ_REQ: begin
        if (pg_done_i) begin
          tmr_d = '0;
          st_d  = SQ_HOLD;
        end
      end
      SQ_HOLD: begin
        if (tmr_q == TMR_END) begin
          if (last_i) begin
            st_d = SQ_IDLE;
          end else begin
            step_o = 1'b1;
            st_d   = SQ_PICK;
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign pg_req_o = (st_q == SQ_REQ);
  assign busy_o   = (st_q == SQ_PICK) || (st_q == SQ_REQ) || (st_q == SQ_HOLD);

endmodule

// File: rtl/cached_page_writer.sv
module cached_page_writer #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 8,
  parameter int CACHE_PAGES = 8,
  parameter int WR_CYCLES   = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_start,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic                                 byte_valid,
  input  logic [7:0]                           byte_data,
  input  logic                                 wr_stop,
  output logic                                 pg_req,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pg_addr,
  output logic [8*PAGE_BYTES-1:0]              pg_data,
  output logic [PAGE_BYTES-1:0]                pg_mask,
  input  logic                                 pg_done,
  output logic                                 busy
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int CPG_W  = $clog2(CACHE_PAGES);
  localparam int CIDX_W = OFS_W + CPG_W;
  localparam int PNUM_W = ADDR_W - OFS_W;

  logic              clr, load, we, step, last, any_vld;
  logic [CIDX_W-1:0] wptr;
  logic [CPG_W-1:0]  cpg;
  logic [PNUM_W-1:0] tgt;

  cpw_ctrl #(
    .WR_CYCLES (WR_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_start_i   (wr_start),
    .byte_valid_i (byte_valid),
    .wr_stop_i    (wr_stop),
    .any_i        (any_vld),
    .page_has_i   (|pg_mask),
    .last_i       (last),
    .pg_done_i    (pg_done),
    .clr_o        (clr),
    .load_o       (load),
    .we_o         (we),
    .step_o       (step),
    .pg_req_o     (pg_req),
    .busy_o       (busy)
  );

  cpw_cursor #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .CACHE_PAGES (CACHE_PAGES)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .addr_i    (wr_addr),
    .adv_ptr_i (we),
    .step_i    (step),
    .wptr_o    (wptr),
    .cpg_o     (cpg),
    .tgt_o     (tgt),
    .last_o    (last)
  );

  cpw_cache_store #(
    .PAGE_BYTES  (PAGE_BYTES),
    .CACHE_PAGES (CACHE_PAGES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .we_i    (we),
    .widx_i  (wptr),
    .wdata_i (byte_data),
    .rpage_i (cpg),
    .rdata_o (pg_data),
    .rmask_o (pg_mask),
    .any_o   (any_vld)
  );

  assign pg_addr = tgt;

endmodule

// File: rtl/cpw_checker.sv
module cpw_checker #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 5
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 wr_stop,
  input logic                                 busy,
  input logic                                 pg_req,
  input logic                                 pg_done,
  input logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pg_addr,
  input logic [8*PAGE_BYTES-1:0]              pg_data,
  input logic [PAGE_BYTES-1:0]                pg_mask
);

  // cycles since the last acknowledged page write, saturating
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= WR_CYCLES;
    end else if (pg_req && pg_done) begin
      gap <= 0;
    end else if (gap < WR_CYCLES) begin
      gap <= gap + 1;
    end
  end

  assert_req_in_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req |-> busy);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && !pg_done) |=> (pg_req && $stable(pg_addr) && $stable(pg_mask) && $stable(pg_data)));

  assert_req_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && pg_done) |=> !pg_req);

  assert_req_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_req) |-> (gap >= WR_CYCLES));

  assert_mask_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req |-> (pg_mask != '0));

  assert_flush_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_stop));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (gap == WR_CYCLES));

endmodule

bind cached_page_writer cpw_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .WR_CYCLES  (WR_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_stop (wr_stop),
  .busy    (busy),
  .pg_req  (pg_req),
  .pg_done (pg_done),
  .pg_addr (pg_addr),
  .pg_data (pg_data),
  .pg_mask (pg_mask)
);

// File: tb/sim_cached_page_writer.sv
`timescale 1ns/1ps
module sim_cached_page_writer;

  localparam int ADDR_W = 13;
  localparam int TWC    = 5;
  localparam int LAT    = 2;
  localparam int PNW    = ADDR_W - 3;

  // {start addr[15:0], byte count[7:0], data seed[7:0], expected page writes[7:0]}
  localparam logic [39:0] VEC [7] = '{
    {16'h0158, 8'd64, 8'h11, 8'd8},  // page boundary, crosses a row
    {16'h001A, 8'd64, 8'h23, 8'd8},  // offset 2, last two bytes roll over
    {16'h027E, 8'd5,  8'h35, 8'd2},  // last page of a row into next row
    {16'h0040, 8'd3,  8'h47, 8'd1},  // short partial page
    {16'h0005, 8'd70, 8'h59, 8'd8},  // overfill, overwrite after wrap
    {16'h0100, 8'd0,  8'h6B, 8'd0},  // stop with nothing loaded
    {16'h01C4, 8'd20, 8'h7D, 8'd3}   // mid-page start, three pages
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_start = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic             byte_valid = 1'b0;
  logic [7:0]       byte_data = '0;
  logic             wr_stop = 1'b0;
  logic             pg_req;
  logic [PNW-1:0]   pg_addr;
  logic [63:0]      pg_data;
  logic [7:0]       pg_mask;
  logic             pg_done = 1'b0;
  logic             busy;

  always #5 clk = ~clk;

  cached_page_writer #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (8),
    .CACHE_PAGES (8),
    .WR_CYCLES   (TWC)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .wr_addr    (wr_addr),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .wr_stop    (wr_stop),
    .pg_req     (pg_req),
    .pg_addr    (pg_addr),
    .pg_data    (pg_data),
    .pg_mask    (pg_mask),
    .pg_done    (pg_done),
    .busy       (busy)
  );

  int     tests = 0;
  int     fails = 0;
  longint cyc = 0;
  longint last_done = 0;
  longint fall_cyc = -1;
  int     nwr = 0;
  int     lat = 0;
  bit     req_q = 0, busy_q = 0, have_done = 0;

  logic [PNW-1:0] log_addr [16];
  logic [63:0]    log_data [16];
  logic [7:0]     log_mask [16];
  logic [7:0]     mdat [64];
  bit             mval [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // array model and edge-timing monitor, all on falling edges
  always @(negedge clk) begin
    if (pg_done) begin
      pg_done = 1'b0;
      lat = 0;
    end else if (pg_req) begin
      if (lat >= LAT) begin
        pg_done = 1'b1;
        if (nwr < 16) begin
          log_addr[nwr] = pg_addr;
          log_data[nwr] = pg_data;
          log_mask[nwr] = pg_mask;
        end
        nwr++;
        last_done = cyc + 1;
        have_done = 1;
        lat = 0;
      end else begin
        lat++;
      end
    end
    if (pg_req && !req_q && have_done)
      chk(cyc - last_done >= TWC + 1, "R7", "request spacing", cyc - last_done, TWC + 1);
    req_q = pg_req;
    if (!busy && busy_q) fall_cyc = cyc;
    busy_q = busy;
  end

  task automatic run_txn(input logic [15:0] addr, input int n, input logic [7:0] seed,
                         input bit swl, input bit poke, input int pre_n,
                         input int exp_cnt, input string tag);
    int         sp, ek, lastk;
    logic [7:0] m;
    bit         ok;
    string      creq;
    for (int i = 0; i < 64; i++) mval[i] = 0;
    nwr = 0;
    fall_cyc = -1;
    sp = int'(addr[ADDR_W-1:3]);
    @(negedge clk);
    wr_start = 1'b1;
    wr_addr  = (pre_n > 0) ? 13'h0300 : addr[ADDR_W-1:0];
    @(negedge clk);
    wr_start = 1'b0;
    if (pre_n > 0) begin
      for (int i = 0; i < pre_n; i++) begin
        byte_valid = 1'b1;
        byte_data  = 8'hEE;
        @(negedge clk);
      end
      byte_valid = 1'b0;
      wr_start = 1'b1;
      wr_addr  = addr[ADDR_W-1:0];
      @(negedge clk);
      wr_start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = (int'(addr[2:0]) + i) % 64;
      byte_valid = 1'b1;
      byte_data  = seed + 8'(i * 13);
      mdat[idx]  = seed + 8'(i * 13);
      mval[idx]  = 1;
      if (swl && i == n - 1) wr_stop = 1'b1;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    if (!(swl && n > 0)) begin
      chk(nwr == 0 && !busy, "R4", {tag, " nothing before stop"}, nwr, 0);
      wr_stop = 1'b1;
      @(negedge clk);
    end
    wr_stop = 1'b0;
    chk(busy == (n > 0), (n > 0) ? "R4" : "R10", {tag, " busy after stop"}, busy, (n > 0));
    for (int t = 0; t < 3000 && busy; t++) begin
      if (poke) begin
        wr_start   = (t == 1);
        wr_addr    = 13'h1000;
        byte_valid = 1'b1;
        byte_data  = 8'h5A;
        wr_stop    = (t == 3);
      end
      @(negedge clk);
    end
    wr_start = 1'b0; byte_valid = 1'b0; wr_stop = 1'b0;
    @(negedge clk);
    ek = 0;
    lastk = -1;
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < 8; b++) m[b] = mval[k*8 + b];
      if (m != 8'h00) begin
        if (ek < nwr && ek < 16) begin
          chk(log_addr[ek] == PNW'(sp + k), "R5", {tag, " target page"},
              log_addr[ek], PNW'(sp + k));
          chk(log_mask[ek] == m, (pre_n > 0) ? "R12" : "R6", {tag, " byte mask"},
              log_mask[ek], m);
          ok = 1;
          for (int b = 0; b < 8; b++)
            if (m[b] && log_data[ek][8*b +: 8] !== mdat[k*8 + b]) ok = 0;
          chk(ok, (int'(addr[2:0]) + n > 64) ? "R3" : "R2", {tag, " page data"},
              log_data[ek], 0);
        end
        ek++;
        lastk = k;
      end
    end
    creq = swl ? "R11" : ((pre_n > 0) ? "R12" : "R6");
    chk(nwr == ek && ek == exp_cnt, creq, {tag, " page write count"}, nwr, exp_cnt);
    if (lastk >= 0)
      chk(fall_cyc == last_done + TWC + (7 - lastk), "R8", {tag, " busy fall edge"},
          fall_cyc - last_done, TWC + (7 - lastk));
    if (poke) begin
      byte_valid = 1'b1;
      byte_data  = 8'hA5;
      wr_stop    = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      wr_stop    = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && nwr == ek, "R9", {tag, " inputs ignored"}, nwr, ek);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !pg_req, "R1", "reset state", {busy, pg_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !pg_req && nwr == 0, "R1", "idle after reset", {busy, pg_req}, 0);

    for (int v = 0; v < 7; v++)
      run_txn(VEC[v][39:24], int'(VEC[v][23:16]), VEC[v][15:8], 1'b0, 1'b0, 0,
              int'(VEC[v][7:0]), $sformatf("vec%0d", v));

    // R11: stop together with the last byte, offset 3, twelve bytes -> two pages
    run_txn(16'h00A3, 12, 8'h40, 1'b1, 1'b0, 0, 2, "stop_with_byte");
    // R9: poke start, bytes and stop while flushing
    run_txn(16'h0200, 16, 8'h90, 1'b0, 1'b1, 0, 2, "busy_poke");
    // R12: five bytes at 0x300 discarded by a restart at 0x051
    run_txn(16'h0051, 3, 8'hC0, 1'b0, 1'b0, 5, 1, "restart");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule